// File: doc/BRIEF.md
# Switched-Capacitor Modulator Phase Sequencer

This block turns a fast free-running clock into the control timing of a second-order, one-bit switched-capacitor sigma-delta modulator. It produces two non-overlapping sampling/integration phases, each with a delayed companion that the analog side uses for bottom-plate switching. It also produces a single-cycle comparator strobe and a bank of nine functional switch enables that set the modulator's topology. The integrators and the comparator sit outside this block.

A comparator period consists of one or more integration cycles followed by one comparator decision. Running more than one integration cycle before the decision gives the loop extra gain. The switch bank selects between reference-based operation and ratiometric operation. Reference-based operation always adds the second sampling capacitor, which raises the first-integrator gain from Cs1/Cint to (Cs1+Cs2)/Cint. Ratiometric operation adds that capacitor only when a gain-boost input asks for it. The mode, the boost request and the cycle count are captured once, at the start of each comparator period, so a conversion never sees a switch change in its middle.

The state machine has eight named states. ST_IDLE is held in reset. ST_LOAD is the dead cycle that opens a period and captures the settings. ST_P1_ON drives phase one. ST_P1_TAIL holds only the delayed phase one. ST_MID_GAP is the dead cycle between the phases. ST_P2_ON drives phase two. ST_P2_TAIL holds only the delayed phase two. ST_LOOP_GAP is the dead cycle before another integration cycle in the same period.

The transitions are as follows. IDLE→LOAD after reset. LOAD→P1_ON. P1_ON stays in place for the phase width, then goes to P1_TAIL. P1_TAIL→MID_GAP. MID_GAP→P2_ON. P2_ON stays in place for the phase width, then goes to P2_TAIL. P2_TAIL goes to LOAD after the last integration cycle of the period, and to LOOP_GAP otherwise. LOOP_GAP→P1_ON.

Top module: `sc_mod_sequencer`

## Requirements
- R1: While reset is asserted, all phase outputs, the strobe and all nine switch enables are 0.
- R2: `ph1` and `ph2` are never high in the same cycle. When either delayed phase falls, both main phases and the other delayed phase are low (a full dead cycle separates the phases).
- R3: Each delayed phase rises in the same cycle as its main phase. It is still high in the cycle its main phase falls, and it falls one cycle later, so it is high for PHASE_W+1 cycles.
- R4: Each main phase stays high for exactly PHASE_W cycles (default 2).
- R5: The number of `ph1` pulses in a comparator period equals the captured `int_cycles`. A value of 0 gives 1 pulse, and values above MAX_INT (default 8) give MAX_INT pulses.
- R6: `cmp_strobe` is high for exactly one cycle per period. That cycle is the last high cycle of `ph2` in the final integration cycle of the period.
- R7: With `mode_ref`=1 (reference-based), `fsw_en` is 9'h173. This sets bit0 (second sampling capacitor), bit1 (reference feedback), bit4 (reference return), bit5 (feed-forward path), bit6 (second integrator) and bit8 (double-sampling). `gain_boost` has no effect in this mode.
- R8: With `mode_ref`=0 (ratiometric), `fsw_en` is 9'h16C when `gain_boost`=0. This sets bit2 (base-emitter feedback), bit3 (scaled difference path), bit5, bit6 and bit8. When `gain_boost`=1, `fsw_en` is 9'h1ED, which adds bit0 and bit7 (extra ratio capacitor).
- R9: The settings are captured in the dead cycle two cycles after the strobe. Input changes made later in a period alter neither the switch enables nor the pulse count of that period.
- R10: `fsw_en` changes only in a cycle where all four phase outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sequencing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_ref | input | 1 | 1 = reference-based, 0 = ratiometric |
| gain_boost | input | 1 | Ratiometric request for the second sampling capacitor |
| int_cycles | input | CFG_W (4) | Integration cycles per comparator decision |
| ph1 | output | 1 | Main phase one |
| ph1_dly | output | 1 | Delayed companion of phase one |
| ph2 | output | 1 | Main phase two |
| ph2_dly | output | 1 | Delayed companion of phase two |
| cmp_strobe | output | 1 | Comparator decision strobe |
| fsw_en | output | 9 | Functional switch enables |

## Verification
The bound checker enforces on every cycle the properties that hold from one edge to the next. These are: phase non-overlap and the dead cycle, the delayed phase rising and falling in step with its main phase, the strobe sitting in the final cycle of phase two, switch changes falling only in dead cycles, a valid switch pattern, and a pulse count within 1..MAX_INT. Only the bench scenarios can show the exact pulse widths, that the count matches the captured setting (including 0 and values above the limit), and that each mode and boost combination yields its documented pattern. They also show that settings changed in the middle of a period take effect only in the following period.

// File: rtl/sc_seq_pkg.sv
package sc_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_P1_ON,
        ST_P1_TAIL,
        ST_MID_GAP,
        ST_P2_ON,
        ST_P2_TAIL,
        ST_LOOP_GAP
    } seq_state_t;

    localparam int NUM_SW = 9;

    // switch bank bit positions
    localparam int SW_BOOST      = 0;
    localparam int SW_REF_FB     = 1;
    localparam int SW_VBE_FB     = 2;
    localparam int SW_DVBE_SCALE = 3;
    localparam int SW_REF_RET    = 4;
    localparam int SW_FFWD       = 5;
    localparam int SW_INT2       = 6;
    localparam int SW_ALPHA_CAP  = 7;
    localparam int SW_CDS        = 8;

    function automatic logic [NUM_SW-1:0] sw_pattern(input logic mode_ref,
                                                     input logic boost);
        logic [NUM_SW-1:0] p;
        p                = '0;
        p[SW_FFWD]       = 1'b1;
        p[SW_INT2]       = 1'b1;
        p[SW_CDS]        = 1'b1;
        if (mode_ref) begin
            p[SW_BOOST]   = 1'b1;
            p[SW_REF_FB]  = 1'b1;
            p[SW_REF_RET] = 1'b1;
        end else begin
            p[SW_VBE_FB]     = 1'b1;
            p[SW_DVBE_SCALE] = 1'b1;
            p[SW_BOOST]      = boost;
            p[SW_ALPHA_CAP]  = boost;
        end
        return p;
    endfunction

endpackage

// File: rtl/sc_seq_settings.sv
module sc_seq_settings
    import sc_seq_pkg::*;
#(
    parameter int MAX_INT = 8,
    parameter int CFG_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              mode_ref,
    input  logic              boost_req,
    input  logic [CFG_W-1:0]  int_cfg,
    output logic [NUM_SW-1:0] sw_en,
    output logic [CFG_W-1:0]  int_total
);

    logic [CFG_W-1:0] int_eff;

    // zero means one cycle, anything above the limit saturates
    always_comb begin
        if (int_cfg == '0) begin
            int_eff = CFG_W'(1);
        end else if (int_cfg > CFG_W'(MAX_INT)) begin
            int_eff = CFG_W'(MAX_INT);
        end else begin
            int_eff = int_cfg;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sw_en     <= '0;
            int_total <= CFG_W'(1);
        end else if (load) begin
            sw_en     <= sw_pattern(mode_ref, boost_req);
            int_total <= int_eff;
        end
    end

endmodule

// File: rtl/sc_seq_fsm.sv
module sc_seq_fsm
    import sc_seq_pkg::*;
#(
    parameter int PHASE_W = 2,
    parameter int CFG_W   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CFG_W-1:0] int_total,
    output seq_state_t       state,
    output logic             load,
    output logic             cmp_pre
);

    localparam int WCNT_W = (PHASE_W > 1) ? $clog2(PHASE_W) : 1;

    seq_state_t        state_nx;
    logic [WCNT_W-1:0] wcnt;
    logic [CFG_W-1:0]  icnt;
    logic              phase_last;
    logic              int_last;

    assign phase_last = (wcnt == WCNT_W'(PHASE_W - 1));
    assign int_last   = (icnt == (int_total - CFG_W'(1)));
    assign load       = (state == ST_LOAD);
    assign cmp_pre    = (state == ST_P2_ON) && phase_last && int_last;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:     state_nx = ST_LOAD;
            ST_LOAD:     state_nx = ST_P1_ON;
            ST_P1_ON:    state_nx = phase_last ? ST_P1_TAIL : ST_P1_ON;
            ST_P1_TAIL:  state_nx = ST_MID_GAP;
            ST_MID_GAP:  state_nx = ST_P2_ON;
            ST_P2_ON:    state_nx = phase_last ? ST_P2_TAIL : ST_P2_ON;
            ST_P2_TAIL:  state_nx = int_last ? ST_LOAD : ST_LOOP_GAP;
            ST_LOOP_GAP: state_nx = ST_P1_ON;
            default:     state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // phase width and integration cycle counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wcnt <= '0;
            icnt <= '0;
        end else begin
            if (((state == ST_P1_ON) || (state == ST_P2_ON)) && !phase_last) begin
                wcnt <= wcnt + WCNT_W'(1);
            end else begin
                wcnt <= '0;
            end
            if (state == ST_LOAD) begin
                icnt <= '0;
            end else if ((state == ST_P2_TAIL) && !int_last) begin
                icnt <= icnt + CFG_W'(1);
            end
        end
    end

endmodule

// File: rtl/sc_seq_out.sv
module sc_seq_out
    import sc_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  seq_state_t state,
    input  logic       cmp_pre,
    output logic       ph1,
    output logic       ph1_dly,
    output logic       ph2,
    output logic       ph2_dly,
    output logic       cmp_strobe
);

    logic ph1_nx, ph1_dly_nx, ph2_nx, ph2_dly_nx;

    always_comb begin
        ph1_nx     = (state == ST_P1_ON);
        ph1_dly_nx = (state == ST_P1_ON) || (state == ST_P1_TAIL);
        ph2_nx     = (state == ST_P2_ON);
        ph2_dly_nx = (state == ST_P2_ON) || (state == ST_P2_TAIL);
    end

    // registered so that the analog clocks come from flops, not decode logic
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph1        <= 1'b0;
            ph1_dly    <= 1'b0;
            ph2        <= 1'b0;
            ph2_dly    <= 1'b0;
            cmp_strobe <= 1'b0;
        end else begin
            ph1        <= ph1_nx;
            ph1_dly    <= ph1_dly_nx;
            ph2        <= ph2_nx;
            ph2_dly    <= ph2_dly_nx;
            cmp_strobe <= cmp_pre;
        end
    end

endmodule

// File: rtl/sc_mod_sequencer.sv
module sc_mod_sequencer
    import sc_seq_pkg::*;
#(
    parameter int  PHASE_W = 2,
    parameter int  MAX_INT = 8,
    localparam int CFG_W   = $clog2(MAX_INT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_ref,
    input  logic              gain_boost,
    input  logic [CFG_W-1:0]  int_cycles,
    output logic              ph1,
    output logic              ph1_dly,
    output logic              ph2,
    output logic              ph2_dly,
    output logic              cmp_strobe,
    output logic [NUM_SW-1:0] fsw_en
);

    seq_state_t       state;
    logic             load;
    logic             cmp_pre;
    logic [CFG_W-1:0] int_total;

    sc_seq_settings #(
        .MAX_INT (MAX_INT),
        .CFG_W   (CFG_W)
    ) settings_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .mode_ref  (mode_ref),
        .boost_req (gain_boost),
        .int_cfg   (int_cycles),
        .sw_en     (fsw_en),
        .int_total (int_total)
    );

    sc_seq_fsm #(
        .PHASE_W (PHASE_W),
        .CFG_W   (CFG_W)
    ) fsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .int_total (int_total),
        .state     (state),
        .load      (load),
        .cmp_pre   (cmp_pre)
    );

    sc_seq_out out_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .state      (state),
        .cmp_pre    (cmp_pre),
        .ph1        (ph1),
        .ph1_dly    (ph1_dly),
        .ph2        (ph2),
        .ph2_dly    (ph2_dly),
        .cmp_strobe (cmp_strobe)
    );

endmodule

// File: rtl/sc_seq_checker.sv
module sc_seq_checker #(
    parameter int MAX_INT = 8
) (
    input logic       clk,
    input logic       rst_n,
    input logic       ph1,
    input logic       ph1_d,
    input logic       ph2,
    input logic       ph2_d,
    input logic       cmp_strobe,
    input logic [8:0] fsw
);

    logic       ph1_q;
    logic [7:0] rise_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph1_q    <= 1'b0;
            rise_cnt <= '0;
        end else begin
            ph1_q <= ph1;
            if (cmp_strobe) begin
                rise_cnt <= '0;
            end else if (ph1 && !ph1_q) begin
                rise_cnt <= rise_cnt + 8'd1;
            end
        end
    end

    assert_no_overlap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(ph1 && ph2));
    assert_dead_after_p1_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ph1_d) |-> (!ph1 && !ph2 && !ph2_d));
    assert_dead_after_p2_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ph2_d) |-> (!ph1 && !ph2 && !ph1_d));
    assert_dly1_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ph1) |-> $rose(ph1_d));
    assert_dly1_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ph1) |-> ph1_d);
    assert_dly1_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ph1) |=> !ph1_d);
    assert_dly2_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ph2) |-> $rose(ph2_d));
    assert_dly2_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ph2) |-> ph2_d);
    assert_dly2_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ph2) |=> !ph2_d);
    assert_strobe_in_p2_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_strobe |-> ph2);
    assert_strobe_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_strobe |=> (!ph2 && !cmp_strobe));
    assert_int_limit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_strobe |-> ((rise_cnt >= 8'd1) && (rise_cnt <= 8'(MAX_INT))));
    assert_sw_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(fsw) |-> (!ph1 && !ph1_d && !ph2 && !ph2_d));
    assert_path_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fsw != 9'h000) |-> (fsw[1] ^ fsw[2]));
    assert_ref_boost_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fsw[1] |-> fsw[0]);

endmodule

bind sc_mod_sequencer sc_seq_checker #(.MAX_INT(MAX_INT)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .ph1        (ph1),
    .ph1_d      (ph1_dly),
    .ph2        (ph2),
    .ph2_d      (ph2_dly),
    .cmp_strobe (cmp_strobe),
    .fsw        (fsw_en)
);

// File: tb/sc_mod_sequencer_tb_top.sv
module sc_mod_sequencer_tb_top;

    localparam int PHASE_W     = 2;
    localparam int MAX_INT     = 8;
    localparam int CFG_W       = 4;
    localparam int NUM_PERIODS = 400;
    localparam int WD_LIMIT    = 400;

    logic             clk        = 1'b0;
    logic             rst_n      = 1'b0;
    logic             mode_ref   = 1'b0;
    logic             gain_boost = 1'b0;
    logic [CFG_W-1:0] int_cycles = 4'd0;
    logic             ph1, ph1_dly, ph2, ph2_dly, cmp_strobe;
    logic [8:0]       fsw_en;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    sc_mod_sequencer #(.PHASE_W(PHASE_W), .MAX_INT(MAX_INT)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_ref   (mode_ref),
        .gain_boost (gain_boost),
        .int_cycles (int_cycles),
        .ph1        (ph1),
        .ph1_dly    (ph1_dly),
        .ph2        (ph2),
        .ph2_dly    (ph2_dly),
        .cmp_strobe (cmp_strobe),
        .fsw_en     (fsw_en)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int exp_total(input logic [CFG_W-1:0] cfg);
        if (cfg == 0) return 1;
        if (int'(cfg) > MAX_INT) return MAX_INT;
        return int'(cfg);
    endfunction

    function automatic logic [8:0] exp_fsw(input logic m, input logic b);
        if (m) return 9'h173;
        return b ? 9'h1ED : 9'h16C;
    endfunction

    // monitor state
    int         since = 0;
    int         rises = 0;
    int         periods = 0;
    int         per_total = 1;
    logic [8:0] per_fsw = '0;
    logic [8:0] fsw_ref = '0;
    int         r1_run = 0, r1d_run = 0, r2_run = 0, r2d_run = 0;
    logic       ph1_q = 0, ph1d_q = 0, ph2_q = 0, ph2d_q = 0, stb_q = 0;
    logic [8:0] fsw_q = '0;
    bit         wd_hit = 0;

    task automatic drive_next(input int idx);
        case (idx)
            0: begin mode_ref = 1'b0; gain_boost = 1'b0; int_cycles = 4'd0;  end
            1: begin mode_ref = 1'b1; gain_boost = 1'b0; int_cycles = 4'd8;  end
            2: begin mode_ref = 1'b0; gain_boost = 1'b1; int_cycles = 4'd15; end
            3: begin mode_ref = 1'b1; gain_boost = 1'b1; int_cycles = 4'd1;  end
            4: begin mode_ref = 1'b0; gain_boost = 1'b0; int_cycles = 4'd9;  end
            default: begin
                mode_ref   = 1'($urandom % 2);
                gain_boost = 1'($urandom % 2);
                int_cycles = CFG_W'($urandom % 16);
            end
        endcase
    endtask

    always @(negedge clk) begin
        if (!rst_n) begin
            // R1: quiet outputs under reset
            chk({ph1, ph1_dly, ph2, ph2_dly, cmp_strobe} == 5'b0, "R1", "phases in reset",
                {ph1, ph1_dly, ph2, ph2_dly, cmp_strobe}, 0);
            chk(fsw_en == 9'h000, "R1", "switches in reset", fsw_en, 0);
            per_total = exp_total(int_cycles);
            per_fsw   = exp_fsw(mode_ref, gain_boost);
        end else if (!wd_hit) begin
            chk(!(ph1 && ph2), "R2", "phase overlap", {ph1, ph2}, 0);

            if (ph1 && !ph1_q) begin
                rises++;
                chk(ph1_dly && !ph1d_q, "R3", "ph1_dly rise with ph1", ph1_dly, 1);
            end
            if (ph2 && !ph2_q)
                chk(ph2_dly && !ph2d_q, "R3", "ph2_dly rise with ph2", ph2_dly, 1);
            if (ph1) r1_run++;
            if (ph1_dly) r1d_run++;
            if (ph2) r2_run++;
            if (ph2_dly) r2d_run++;
            if (ph1_q && !ph1) begin
                chk(r1_run == PHASE_W, "R4", "ph1 width", r1_run, PHASE_W);
                chk(ph1_dly, "R3", "ph1_dly held after ph1 fall", ph1_dly, 1);
                r1_run = 0;
            end
            if (ph2_q && !ph2) begin
                chk(r2_run == PHASE_W, "R4", "ph2 width", r2_run, PHASE_W);
                chk(ph2_dly, "R3", "ph2_dly held after ph2 fall", ph2_dly, 1);
                r2_run = 0;
            end
            if (ph1d_q && !ph1_dly) begin
                chk(r1d_run == PHASE_W + 1, "R3", "ph1_dly width", r1d_run, PHASE_W + 1);
                chk(!ph1 && !ph2 && !ph2_dly, "R2", "dead cycle after phase one",
                    {ph1, ph2, ph2_dly}, 0);
                r1d_run = 0;
            end
            if (ph2d_q && !ph2_dly) begin
                chk(r2d_run == PHASE_W + 1, "R3", "ph2_dly width", r2d_run, PHASE_W + 1);
                chk(!ph1 && !ph2 && !ph1_dly, "R2", "dead cycle after phase two",
                    {ph1, ph2, ph1_dly}, 0);
                r2d_run = 0;
            end
            if (fsw_en != fsw_q)
                chk(!ph1 && !ph1_dly && !ph2 && !ph2_dly, "R10", "switch change during phase",
                    {ph1, ph1_dly, ph2, ph2_dly}, 0);
            if (stb_q)
                chk(!ph2 && !cmp_strobe, "R6", "strobe not in last ph2 cycle",
                    {ph2, cmp_strobe}, 0);

            if (cmp_strobe) begin
                chk(ph2, "R6", "strobe outside ph2", ph2, 1);
                chk(rises == per_total, "R5", "ph1 pulses per period", rises, per_total);
                // inputs present now are captured at the next LOAD
                per_total = exp_total(int_cycles);
                per_fsw   = exp_fsw(mode_ref, gain_boost);
                rises     = 0;
                since     = 0;
                periods++;
            end else begin
                since++;
            end

            if (since == 3 && periods > 0) begin
                chk(fsw_en == per_fsw, (per_fsw == 9'h173) ? "R7" : "R8",
                    "switch pattern", fsw_en, per_fsw);
                fsw_ref = fsw_en;
            end
            if (since > 3 && periods > 0)
                chk(fsw_en == fsw_ref, "R9", "switches moved mid-period", fsw_en, fsw_ref);
            // mid-period input changes, one or two per period
            if (since == 4) drive_next(periods - 1);
            if (since == 6 && periods > 5 && ($urandom % 3 == 0)) drive_next(99);
            if (since > WD_LIMIT) begin
                wd_hit = 1;
                chk(0, "R6", "watchdog: no strobe", since, WD_LIMIT);
            end
        end
        ph1_q  = ph1;
        ph1d_q = ph1_dly;
        ph2_q  = ph2;
        ph2d_q = ph2_dly;
        stb_q  = cmp_strobe;
        fsw_q  = fsw_en;
    end

    initial begin
        void'($urandom(32'd20250611));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        while (periods < NUM_PERIODS && !wd_hit) @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule